// File: doc/BRIEF.md
# Buffer-Threshold Flow Control Unit

This block sits beside the shared packet buffer of a multi-port switch and decides, for every port, whether the link partner must be held off. It watches one shared count of free buffer pages, where each page is 128 bytes and the default buffer holds 1024 pages. It compares that count against a low-water threshold that configuration sets at start-up.

A port in full duplex is held off with PAUSE frames. When space first runs short, the block asks the frame builder for a PAUSE carrying the maximum pause time. When space has recovered by a margin, it asks for a PAUSE carrying zero time. Each request stays up until the transmitter acknowledges that the frame went out.

A port in half duplex is held off by collisions instead. While space is short and carrier is present on that port's receive side, the block raises a jam enable for the jam pattern generator. It keeps that enable up until there is room for one more maximum-size frame. That margin is 12 pages above the threshold, and the same margin is the release point for full duplex.

Top module: `buf_flow_ctrl`

## Requirements
- R1: During and after reset every pause_req and jam_en is low, and a port's pause_time field reads 0x0000 whenever its pause_req is low.
- R2: A full-duplex port that is not paused, has no pending request and sees free_pages < threshold raises pause_req with pause_time 0xFFFF one cycle later, and becomes paused.
- R3: A pending request and its pause_time hold unchanged until pause_ack is sampled high together with pause_req. pause_req drops in the next cycle. pause_ack while no request is pending has no effect.
- R4: A paused port issues no further request while free_pages stays below threshold + 12, so each congestion episode gives exactly one 0xFFFF request.
- R5: A paused full-duplex port with no pending request and free_pages >= threshold + 12 raises pause_req with pause_time 0x0000 one cycle later, and leaves the paused state. At threshold + 11 no release is requested.
- R6: A half-duplex port with carrier high and free_pages < threshold raises jam_en one cycle later. A full-duplex port, or a port without carrier, has jam_en low one cycle later.
- R7: Once jam_en is high it stays high while carrier stays high and free_pages < threshold + 12, even with free_pages at or above threshold. It falls one cycle after free_pages reaches threshold + 12 or carrier drops.
- R8: One cycle after a port enters half duplex its pause_req is low, any pending request is discarded and its paused state is cleared. A return to full duplex while space is short therefore gives a new 0xFFFF request.
- R9: Ports act independently, each on its own duplex, carrier and acknowledge inputs, against the shared free count and threshold.
- R10: With threshold 0 space is never short: no 0xFFFF request and no jam is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| free_pages | input | 11 | Free page count of the shared buffer |
| threshold | input | 11 | Low-water threshold in pages |
| full_duplex | input | 5 | Per port: 1 full duplex, 0 half duplex |
| carrier | input | 5 | Per port receive-side carrier sense |
| pause_ack | input | 5 | Per port: requested PAUSE frame has been sent |
| pause_req | output | 5 | Per port PAUSE frame request |
| pause_time | output | 80 | Per port 16-bit pause time, port p at bits [16p+15:16p] |
| jam_en | output | 5 | Per port jam enable |

## Verification
The bench walks the free count through both band edges: threshold minus one, threshold, threshold + 11 and threshold + 12. An off-by-one comparison would request the release one page early, or keep jamming a page too long. It holds acknowledges back and repeats them, so that a design that dropped a request early, or re-armed PAUSE-ON within one episode, shows up as a missing or extra request. It also switches a port with a pending request from full to half duplex and back. A design that kept stale paused state would then issue no fresh 0xFFFF request. Sweeps over several thresholds, including 0 and the full buffer size, run all five ports in mixed modes against a cycle model.

// File: rtl/fc_pkg.sv
package fc_pkg;

    localparam int PAUSE_W = 16;
    localparam logic [PAUSE_W-1:0] PAUSE_ON  = '1;
    localparam logic [PAUSE_W-1:0] PAUSE_OFF = '0;

    // Space bands relative to the threshold
    typedef enum logic [1:0] {
        LVL_SHORT = 2'd0,   // below threshold
        LVL_MID   = 2'd1,   // hysteresis band
        LVL_ROOM  = 2'd2    // at least one frame of margin above threshold
    } level_e;

    typedef struct packed {
        logic               valid;
        logic [PAUSE_W-1:0] quanta;
    } pause_cmd_t;

    typedef struct packed {
        logic paused;
        logic jamming;
    } port_state_t;

    function automatic level_e classify(input int unsigned free_n,
                                        input int unsigned thr,
                                        input int unsigned room);
        if (free_n < thr)
            return LVL_SHORT;
        else if (free_n >= thr + room)
            return LVL_ROOM;
        else
            return LVL_MID;
    endfunction

endpackage

// File: rtl/fc_level_cmp.sv
module fc_level_cmp
    import fc_pkg::*;
#(
    parameter int unsigned PG_W       = 11,
    parameter int unsigned ROOM_PAGES = 12
) (
    input  logic [PG_W-1:0] free_pages,
    input  logic [PG_W-1:0] threshold,
    output level_e          level
);

    always_comb begin
        level = classify(32'(free_pages), 32'(threshold), ROOM_PAGES);
    end

endmodule

// File: rtl/fc_port_ctrl.sv
module fc_port_ctrl
    import fc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  level_e             level,
    input  logic               full_dup,
    input  logic               crs,
    input  logic               ack,
    output logic               req,
    output logic [PAUSE_W-1:0] quanta,
    output logic               jam
);

    pause_cmd_t  cmd;
    port_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
            st  <= '0;
        end else begin
            if (!full_dup) begin
                cmd       <= '0;
                st.paused <= 1'b0;
            end else if (cmd.valid) begin
                if (ack)
                    cmd <= '0;
            end else if (!st.paused && level == LVL_SHORT) begin
                cmd       <= '{valid: 1'b1, quanta: PAUSE_ON};
                st.paused <= 1'b1;
            end else if (st.paused && level == LVL_ROOM) begin
                cmd       <= '{valid: 1'b1, quanta: PAUSE_OFF};
                st.paused <= 1'b0;
            end

            st.jamming <= !full_dup && crs &&
                          (st.jamming ? (level != LVL_ROOM) : (level == LVL_SHORT));
        end
    end

    assign req    = cmd.valid;
    assign quanta = cmd.quanta;
    assign jam    = st.jamming;

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !req |-> quanta == PAUSE_OFF);

    p_on_when_short_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(req) && quanta == PAUSE_ON) |-> $past(level == LVL_SHORT));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (req && !ack && full_dup) |=> (req && $stable(quanta)));

    p_ack_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (req && ack) |=> !req);

    p_off_when_room_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(req) && quanta == PAUSE_OFF) |-> $past(level == LVL_ROOM));

    p_jam_start_r6: assert property (@(posedge clk) disable iff (rst)
        (!full_dup && crs && level == LVL_SHORT) |=> jam);

    p_no_jam_r6: assert property (@(posedge clk) disable iff (rst)
        (full_dup || !crs) |=> !jam);

    p_jam_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (jam && !full_dup && crs && level != LVL_ROOM) |=> jam);

    p_half_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !full_dup |=> !req);

endmodule

// File: rtl/buf_flow_ctrl.sv
module buf_flow_ctrl
    import fc_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 5,
    parameter int unsigned TOTAL_PAGES = 1024,
    parameter int unsigned ROOM_PAGES  = 12,
    localparam int unsigned PG_W       = $clog2(TOTAL_PAGES + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [PG_W-1:0]                free_pages,
    input  logic [PG_W-1:0]                threshold,
    input  logic [NUM_PORTS-1:0]           full_duplex,
    input  logic [NUM_PORTS-1:0]           carrier,
    input  logic [NUM_PORTS-1:0]           pause_ack,
    output logic [NUM_PORTS-1:0]           pause_req,
    output logic [NUM_PORTS*PAUSE_W-1:0]   pause_time,
    output logic [NUM_PORTS-1:0]           jam_en
);

    level_e level;

    fc_level_cmp #(
        .PG_W       (PG_W),
        .ROOM_PAGES (ROOM_PAGES)
    ) u_level (
        .free_pages (free_pages),
        .threshold  (threshold),
        .level      (level)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        fc_port_ctrl u_port (
            .clk      (clk),
            .rst      (rst),
            .level    (level),
            .full_dup (full_duplex[p]),
            .crs      (carrier[p]),
            .ack      (pause_ack[p]),
            .req      (pause_req[p]),
            .quanta   (pause_time[p*PAUSE_W +: PAUSE_W]),
            .jam      (jam_en[p])
        );
    end

endmodule

// File: tb/buf_flow_ctrl_bench.sv
module buf_flow_ctrl_bench;

    localparam int NP   = 5;
    localparam int TOT  = 1024;
    localparam int ROOM = 12;
    localparam int PGW  = $clog2(TOT + 1);

    logic            clk = 1'b0;
    logic            rst;
    logic [PGW-1:0]  free_pages;
    logic [PGW-1:0]  threshold;
    logic [NP-1:0]   full_duplex, carrier, pause_ack;
    logic [NP-1:0]   pause_req, jam_en;
    logic [NP*16-1:0] pause_time;

    int checks = 0;
    int errors = 0;

    logic        m_req    [NP];
    logic [15:0] m_time   [NP];
    logic        m_paused [NP];
    logic        m_jam    [NP];

    always #5 clk = ~clk;

    buf_flow_ctrl u_buf_flow_ctrl (
        .clk         (clk),
        .rst         (rst),
        .free_pages  (free_pages),
        .threshold   (threshold),
        .full_duplex (full_duplex),
        .carrier     (carrier),
        .pause_ack   (pause_ack),
        .pause_req   (pause_req),
        .pause_time  (pause_time),
        .jam_en      (jam_en)
    );

    task automatic check(input string tag, input int p, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s port %0d %s actual %0h expected %0h", tag, p, what, act, exp);
        end
    endtask

    // Reference model from the requirements, then compare after the edge
    task automatic step(input string tag);
        @(posedge clk);
        for (int p = 0; p < NP; p++) begin
            bit short_s = int'(free_pages) < int'(threshold);
            bit room_s  = int'(free_pages) >= int'(threshold) + ROOM;
            if (rst) begin
                m_req[p] = 0; m_time[p] = 0; m_paused[p] = 0; m_jam[p] = 0;
            end else begin
                m_jam[p] = !full_duplex[p] && carrier[p] &&
                           (m_jam[p] ? !room_s : short_s);
                if (!full_duplex[p]) begin
                    m_req[p] = 0; m_time[p] = 0; m_paused[p] = 0;
                end else if (m_req[p]) begin
                    if (pause_ack[p]) begin m_req[p] = 0; m_time[p] = 0; end
                end else if (!m_paused[p] && short_s) begin
                    m_req[p] = 1; m_time[p] = 16'hFFFF; m_paused[p] = 1;
                end else if (m_paused[p] && room_s) begin
                    m_req[p] = 1; m_time[p] = 16'h0000; m_paused[p] = 0;
                end
            end
        end
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            check(tag, p, "pause_req", 16'(pause_req[p]), 16'(m_req[p]));
            check(tag, p, "pause_time", pause_time[p*16 +: 16], m_time[p]);
            check(tag, p, "jam_en", 16'(jam_en[p]), 16'(m_jam[p]));
        end
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; free_pages = 11'd1024; threshold = 11'd100;
        full_duplex = '1; carrier = '0; pause_ack = '0;
        for (int p = 0; p < NP; p++) begin
            m_req[p] = 0; m_time[p] = 0; m_paused[p] = 0; m_jam[p] = 0;
        end
        @(negedge clk);
        step("R1"); step("R1");
        rst = 0;
        step("R1");
        pause_ack = '1;                 // ack without request: no effect
        step("R3");
        pause_ack = '0;
        free_pages = 11'd100;           // at threshold: not short
        step("R2");
        free_pages = 11'd99;
        step("R2");
        step("R3"); step("R3"); step("R3");
        pause_ack = 5'b00011;           // only ports 0 and 1 acknowledge
        step("R3");
        pause_ack = '1;
        step("R3");
        pause_ack = '0;
        free_pages = 11'd40;
        step("R4"); step("R4");
        free_pages = 11'd111;           // threshold + 11: no release
        step("R5"); step("R5");
        free_pages = 11'd112;           // threshold + 12: release
        step("R5"); step("R5");
        pause_ack = '1;
        step("R5");
        pause_ack = '0;
        step("R5");
        // half duplex jamming
        full_duplex = '0; carrier = 5'b00011; free_pages = 11'd50;
        step("R6"); step("R6");
        free_pages = 11'd105;
        step("R7");
        free_pages = 11'd111;
        step("R7");
        free_pages = 11'd112;
        step("R7");
        free_pages = 11'd50;
        step("R7");
        carrier = 5'b00001;
        step("R7");
        carrier = '0;
        step("R6");
        // mode change with pending request
        full_duplex = 5'b00100;
        step("R8");
        step("R8");
        full_duplex = 5'b00000;
        step("R8");
        full_duplex = 5'b00100;
        step("R8"); step("R8");
        // threshold zero
        rst = 1; step("R1"); rst = 0;
        threshold = 11'd0; free_pages = 11'd0;
        full_duplex = 5'b10101; carrier = '1;
        step("R10"); step("R10"); step("R10");
        // sweeps over thresholds with mixed modes
        for (int t = 0; t < 5; t++) begin
            case (t)
                0: threshold = 11'd0;
                1: threshold = 11'd1;
                2: threshold = 11'd37;
                3: threshold = 11'd1012;
                default: threshold = 11'd1024;
            endcase
            for (int dir = 0; dir < 2; dir++) begin
                for (int i = 0; i <= TOT; i++) begin
                    free_pages  = PGW'(dir == 0 ? TOT - i : i);
                    full_duplex = 5'b10011 ^ {4'b0, i[9]};
                    carrier     = PGW'(i) % 7 == 0 ? 5'b01010 : 5'b11100 ^ {i[6:4], 2'b0};
                    pause_ack   = {i[1:0] == 2'd3, i[2], i[3] & i[0], i[4:0] == 5'd7, i[1]};
                    step("R9");
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule